// File: doc/BRIEF.md
# PCIe Root Port Reset Sequencer

This block brings a PCIe root port out of reset and then waits for the link to come up. A one-cycle start request makes it pull every internal reset and the card reset line low together. It then releases the internal resets one lane per cycle, in a fixed order, while the card reset stays low. The card reset stays low for a settle period so that the internal reset flow can finish and the reference clock can become stable.

After the card reset is released, the sequencer waits out a mandatory period and ignores link-up for that whole time. It then polls link-up at a fixed interval, inside a bounded window. If a poll sees link-up, the sequence ends in done. If the window runs out first, the sequence ends in error, and the LTSSM state present at that moment is held for diagnosis. Every delay is a parameter counted in clock cycles, so a small set of values can be used in simulation. The PHY and the LTSSM itself sit outside this block.

Top module: `rootport_reset_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, every output is 0. That means `core_rst_n`, `card_rst_n`, `busy`, `done`, `err` and `fail_ltssm` are all 0, so all resets are asserted.
- R2: A start accepted at a clock edge holds `core_rst_n` and `card_rst_n` all low for ASSERT_CYC cycles. Over the next NUM_RST cycles, `core_rst_n` bits go high one per cycle, bit 0 first and bit NUM_RST-1 last, and they stay high afterwards.
- R3: `card_rst_n` stays low for PERST_HOLD_CYC cycles after the cycle in which the last core lane is released. It then goes high and stays high until the next start.
- R4: For POST_PERST_CYC cycles after `card_rst_n` rises, `link_up` has no effect. After that, `link_up` is sampled only in window cycles POLL_CYC-1, 2*POLL_CYC-1 and so on, counted from 0. A level that is high only between those cycles is not seen.
- R5: A sample that finds `link_up` high raises `done` on the following cycle. `done` stays high until the next accepted start.
- R6: If no sample finds `link_up` high within LINK_TIMEOUT_CYC window cycles, `err` rises and `fail_ltssm` takes the value `ltssm_state` had at that final edge. When a sample and the end of the window fall on the same edge, the sample wins.
- R7: `busy` is high from the cycle after an accepted start until the cycle in which `done` or `err` rises. It is never high together with `done` or `err`.
- R8: A start that arrives while `busy` is high is ignored, and the sequence continues unchanged.
- R9: A start accepted from the done or error state restarts the sequence from the all-asserted step. It clears `done`, `err` and `fail_ltssm` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| start | input | 1 | One-cycle request to run the sequence |
| link_up | input | 1 | Link-trained status from the LTSSM |
| ltssm_state | input | LTSSM_W | Current LTSSM state code |
| core_rst_n | output | NUM_RST | Active-low internal resets, bit 0 released first |
| card_rst_n | output | 1 | Active-low reset to the card |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Link came up (sticky) |
| err | output | 1 | Link-up timeout (sticky) |
| fail_ltssm | output | LTSSM_W | LTSSM state captured at timeout |

## Verification
The assertions assume that `start` is a single-cycle request and that `rst_n` is held low for at least one clock edge before the first start. Beyond that, they make no assumption about when `link_up` toggles. The stimulus starts each run with a one-cycle pulse. It drives `link_up` as a function of where the sequence is at that moment: held high from the start, rising in the middle of the window, a lone pulse between two sample points, a level present only at the final sample, and never. This covers every way the poll can end without creating request patterns outside that assumption.

// File: rtl/rootport_reset_seq_pkg.sv
// Package: shared state encoding and a width helper for the reset sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package rootport_reset_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASSERT_ALL,
        ST_RELEASE_CORE,
        ST_HOLD_CARD,
        ST_POST_WAIT,
        ST_POLL_LINK,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    // Larger of two counts, used to size the shared state timer.
    function automatic int unsigned seq_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rootport_reset_seq_timer.sv
// Module: cycle counter with a synchronous restart.
// WRAP == 0 gives a saturating up-counter. WRAP > 0 gives a counter that
// returns to zero after WRAP-1. Assumes W is wide enough for WRAP-1.
module rootport_reset_seq_timer #(
    parameter int unsigned W    = 8,
    parameter int unsigned WRAP = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count_q
);
    logic [W-1:0] count_d;

    generate
        if (WRAP == 0) begin : g_sat
            // Next count: clear on restart, otherwise add one and stop at all ones.
            always_comb begin
                if (restart)       count_d = '0;
                else if (&count_q) count_d = count_q;
                else               count_d = count_q + 1'b1;
            end
        end else begin : g_wrap
            localparam logic [W-1:0] LAST = W'(WRAP - 1);
            // Next count: clear on restart or after the last value.
            always_comb begin
                if (restart || count_q == LAST) count_d = '0;
                else                            count_d = count_q + 1'b1;
            end
        end
    endgenerate

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end
endmodule

// File: rtl/rootport_reset_seq_fsm.sv
// Module: sequencing state machine. It works out the next state from the
// cycle-in-state count and the poll phase, and flags state changes and the
// timeout capture. Assumes each cycle parameter is at least 1.
module rootport_reset_seq_fsm
    import rootport_reset_seq_pkg::*;
#(
    parameter int unsigned NUM_RST          = 3,
    parameter int unsigned ASSERT_CYC       = 4,
    parameter int unsigned PERST_HOLD_CYC   = 20,
    parameter int unsigned POST_PERST_CYC   = 15,
    parameter int unsigned POLL_CYC         = 4,
    parameter int unsigned LINK_TIMEOUT_CYC = 32,
    parameter int unsigned CNT_W            = 8,
    parameter int unsigned POLL_W           = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              link_up,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [POLL_W-1:0] poll_q,
    output seq_state_e        state_q,
    output seq_state_e        state_d,
    output logic              restart,
    output logic              poll_run,
    output logic              cap_en
);
    localparam logic [CNT_W-1:0]  LIM_ASSERT  = CNT_W'(ASSERT_CYC - 1);
    localparam logic [CNT_W-1:0]  LIM_RELEASE = CNT_W'(NUM_RST - 1);
    localparam logic [CNT_W-1:0]  LIM_HOLD    = CNT_W'(PERST_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0]  LIM_POST    = CNT_W'(POST_PERST_CYC - 1);
    localparam logic [CNT_W-1:0]  LIM_WINDOW  = CNT_W'(LINK_TIMEOUT_CYC - 1);
    localparam logic [POLL_W-1:0] LIM_POLL    = POLL_W'(POLL_CYC - 1);

    logic poll_tick;

    // Poll point: the last cycle of each poll interval inside the window.
    assign poll_run  = (state_q == ST_POLL_LINK);
    assign poll_tick = poll_run && (poll_q == LIM_POLL);

    // Next-state decode. A sample that sees link-up wins over the timeout.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL:
                if (start) state_d = ST_ASSERT_ALL;
            ST_ASSERT_ALL:
                if (cnt_q == LIM_ASSERT) state_d = ST_RELEASE_CORE;
            ST_RELEASE_CORE:
                if (cnt_q == LIM_RELEASE) state_d = ST_HOLD_CARD;
            ST_HOLD_CARD:
                if (cnt_q == LIM_HOLD) state_d = ST_POST_WAIT;
            ST_POST_WAIT:
                if (cnt_q == LIM_POST) state_d = ST_POLL_LINK;
            ST_POLL_LINK:
                if (poll_tick && link_up)   state_d = ST_DONE;
                else if (cnt_q == LIM_WINDOW) state_d = ST_FAIL;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // A state change restarts the cycle-in-state timer; leaving the poll window for FAIL captures the LTSSM.
    assign restart = (state_d != state_q);
    assign cap_en  = (state_q == ST_POLL_LINK) && (state_d == ST_FAIL);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/rootport_reset_seq_outreg.sv
// Module: output registers. Each output is registered from the next state,
// so the outputs follow the state register with no combinational path to
// the ports. Assumes cnt_q is the cycle-in-state count of the current state.
module rootport_reset_seq_outreg
    import rootport_reset_seq_pkg::*;
#(
    parameter int unsigned NUM_RST = 3,
    parameter int unsigned LTSSM_W = 6,
    parameter int unsigned CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_state_e         state_d,
    input  logic               restart,
    input  logic [CNT_W-1:0]   cnt_q,
    input  logic               cap_en,
    input  logic [LTSSM_W-1:0] ltssm_state,
    output logic [NUM_RST-1:0] core_rst_n,
    output logic               card_rst_n,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [LTSSM_W-1:0] fail_ltssm
);
    logic [CNT_W-1:0]   stage_d;
    logic [NUM_RST-1:0] core_d;

    // Release stage in the next cycle: 0 on entry, otherwise one more than now.
    assign stage_d = restart ? '0 : cnt_q + 1'b1;

    generate
        for (genvar i = 0; i < NUM_RST; i++) begin : g_lane
            // Lane i is released once the stage reaches i, and stays released after that step.
            always_comb begin
                unique case (state_d)
                    ST_IDLE, ST_ASSERT_ALL: core_d[i] = 1'b0;
                    ST_RELEASE_CORE:        core_d[i] = (stage_d >= CNT_W'(i));
                    default:                core_d[i] = 1'b1;
                endcase
            end
        end
    endgenerate

    // Reset lines and status flags, all low while the block is in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_rst_n <= '0;
            card_rst_n <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            core_rst_n <= core_d;
            card_rst_n <= (state_d == ST_POST_WAIT) || (state_d == ST_POLL_LINK) ||
                          (state_d == ST_DONE)      || (state_d == ST_FAIL);
            busy       <= (state_d != ST_IDLE) && (state_d != ST_DONE) && (state_d != ST_FAIL);
            done       <= (state_d == ST_DONE);
            err        <= (state_d == ST_FAIL);
        end
    end

    // LTSSM capture on timeout, cleared whenever a new run begins.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   fail_ltssm <= '0;
        else if (cap_en)                              fail_ltssm <= ltssm_state;
        else if (restart && state_d == ST_ASSERT_ALL) fail_ltssm <= '0;
    end
endmodule

// File: rtl/rootport_reset_seq.sv
// Module: PCIe root port reset sequencer (top). It asserts all resets, releases
// the internal lanes in order, holds the card reset for a settle time, waits
// after releasing it, then polls link-up inside a bounded window. Assumes start
// is a one-cycle pulse and that every cycle parameter is at least 1.
module rootport_reset_seq
    import rootport_reset_seq_pkg::*;
#(
    parameter int unsigned NUM_RST          = 3,
    parameter int unsigned LTSSM_W          = 6,
    parameter int unsigned ASSERT_CYC       = 4,
    parameter int unsigned PERST_HOLD_CYC   = 20,
    parameter int unsigned POST_PERST_CYC   = 15,
    parameter int unsigned POLL_CYC         = 4,
    parameter int unsigned LINK_TIMEOUT_CYC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               link_up,
    input  logic [LTSSM_W-1:0] ltssm_state,
    output logic [NUM_RST-1:0] core_rst_n,
    output logic               card_rst_n,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [LTSSM_W-1:0] fail_ltssm
);
    localparam int unsigned MAX_LIM = seq_max(seq_max(seq_max(ASSERT_CYC, NUM_RST),
                                              seq_max(PERST_HOLD_CYC, POST_PERST_CYC)),
                                              LINK_TIMEOUT_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1) + 1;
    localparam int unsigned POLL_W  = $clog2(POLL_CYC + 1);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic              restart;
    logic              poll_run;
    logic              cap_en;
    logic [CNT_W-1:0]  cnt_q;
    logic [POLL_W-1:0] poll_q;

    rootport_reset_seq_timer #(.W(CNT_W), .WRAP(0)) u_state_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count_q (cnt_q)
    );

    rootport_reset_seq_timer #(.W(POLL_W), .WRAP(POLL_CYC)) u_poll_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (!poll_run),
        .count_q (poll_q)
    );

    rootport_reset_seq_fsm #(
        .NUM_RST(NUM_RST), .ASSERT_CYC(ASSERT_CYC), .PERST_HOLD_CYC(PERST_HOLD_CYC),
        .POST_PERST_CYC(POST_PERST_CYC), .POLL_CYC(POLL_CYC),
        .LINK_TIMEOUT_CYC(LINK_TIMEOUT_CYC), .CNT_W(CNT_W), .POLL_W(POLL_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .link_up  (link_up),
        .cnt_q    (cnt_q),
        .poll_q   (poll_q),
        .state_q  (state_q),
        .state_d  (state_d),
        .restart  (restart),
        .poll_run (poll_run),
        .cap_en   (cap_en)
    );

    rootport_reset_seq_outreg #(.NUM_RST(NUM_RST), .LTSSM_W(LTSSM_W), .CNT_W(CNT_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_d     (state_d),
        .restart     (restart),
        .cnt_q       (cnt_q),
        .cap_en      (cap_en),
        .ltssm_state (ltssm_state),
        .core_rst_n  (core_rst_n),
        .card_rst_n  (card_rst_n),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .fail_ltssm  (fail_ltssm)
    );
endmodule

// File: rtl/rootport_reset_seq_chk.sv
// Module: port-level checker for the reset sequencer, bound to the top module.
// Assumes start is a one-cycle pulse.
module rootport_reset_seq_chk #(
    parameter int unsigned NUM_RST = 3,
    parameter int unsigned LTSSM_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [NUM_RST-1:0] core_rst_n,
    input logic               card_rst_n,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic [LTSSM_W-1:0] fail_ltssm
);
    generate
        for (genvar i = 1; i < NUM_RST; i++) begin : g_order
            // R2
            release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                core_rst_n[i] |-> core_rst_n[i-1]);
        end
    endgenerate

    // R3
    card_after_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_n |-> (&core_rst_n));

    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> (err && $stable(fail_ltssm)));

    // R7
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(done || err));

    // R5
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R8
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind rootport_reset_seq rootport_reset_seq_chk #(.NUM_RST(NUM_RST), .LTSSM_W(LTSSM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .core_rst_n (core_rst_n),
    .card_rst_n (card_rst_n),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .fail_ltssm (fail_ltssm)
);

// File: tb/test_rootport_reset_seq.sv
`timescale 1ns/1ps
// Bench: a behavioural phase/time model compared against the ports on every falling edge.
module test_rootport_reset_seq;
    localparam int NR = 3;
    localparam int LW = 6;
    localparam int A  = 4;
    localparam int H  = 20;
    localparam int P  = 15;
    localparam int Q  = 4;
    localparam int T  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic link_up = 1'b0;
    logic [LW-1:0] ltssm_state = '0;
    logic [NR-1:0] core_rst_n;
    logic card_rst_n, busy, done, err;
    logic [LW-1:0] fail_ltssm;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    // Model: phase 0 idle, 1 all asserted, 2 releasing, 3 holding card, 4 post wait, 5 polling, 6 done, 7 failed.
    int mph = 0;
    int mt  = 0;
    logic [LW-1:0] mcap = '0;

    rootport_reset_seq #(
        .NUM_RST(NR), .LTSSM_W(LW), .ASSERT_CYC(A), .PERST_HOLD_CYC(H),
        .POST_PERST_CYC(P), .POLL_CYC(Q), .LINK_TIMEOUT_CYC(T)
    ) i_rootport_reset_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .link_up(link_up),
        .ltssm_state(ltssm_state), .core_rst_n(core_rst_n), .card_rst_n(card_rst_n),
        .busy(busy), .done(done), .err(err), .fail_ltssm(fail_ltssm)
    );

    always #2.5 clk = ~clk;

    // Model update at each rising edge.
    always @(posedge clk) begin
        int nxt;
        cyc++;
        if (!rst_n) begin
            mph = 0; mt = 0; mcap = '0;
        end else begin
            nxt = mph;
            if (mph == 0 || mph == 6 || mph == 7) begin
                if (start) nxt = 1;
            end else if (mph == 1) begin
                if (mt == A - 1) nxt = 2;
            end else if (mph == 2) begin
                if (mt == NR - 1) nxt = 3;
            end else if (mph == 3) begin
                if (mt == H - 1) nxt = 4;
            end else if (mph == 4) begin
                if (mt == P - 1) nxt = 5;
            end else if (mph == 5) begin
                if (((mt + 1) % Q) == 0 && link_up) nxt = 6;
                else if (mt == T - 1) begin nxt = 7; mcap = ltssm_state; end
            end
            if (nxt == 1 && mph != 1) mcap = '0;
            mt  = (nxt != mph) ? 0 : mt + 1;
            mph = nxt;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison of every port against the model.
    always @(negedge clk) begin
        logic [NR-1:0] ecore;
        for (int i = 0; i < NR; i++)
            ecore[i] = (mph >= 3) || (mph == 2 && i <= mt);
        check("R2", "core_rst_n", int'(core_rst_n), int'(ecore));
        check("R3", "card_rst_n", int'(card_rst_n), int'(mph >= 4));
        check("R7", "busy", int'(busy), int'(mph >= 1 && mph <= 5));
        check("R5", "done", int'(done), int'(mph == 6));
        check("R6", "err", int'(err), int'(mph == 7));
        check("R6", "fail_ltssm", int'(fail_ltssm), int'(mcap));
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            report();
        end
    end

    // Run one sequence; mode picks how link_up behaves in the poll window.
    task automatic run_seq(input int mode, input logic [LW-1:0] code, output int lat);
        @(negedge clk);
        start = 1'b1;
        ltssm_state = code;
        lat = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        for (int k = 0; k < 300; k++) begin
            if (mph == 6 || mph == 7) break;
            case (mode)
                0: link_up = 1'b1;
                1: link_up = (mph == 5 && mt >= 9);
                2: link_up = 1'b0;
                3: link_up = (mph == 5 && mt == T - 1);
                4: link_up = (mph == 5 && mt == 5);
                default: link_up = 1'b0;
            endcase
            @(negedge clk);
            lat++;
        end
        link_up = 1'b0;
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1: outputs while in reset
        check("R1", "reset core/card/busy/done/err/cap",
              int'({core_rst_n, card_rst_n, busy, done, err, fail_ltssm}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "idle after reset", int'({core_rst_n, card_rst_n, busy}), 0);

        // R4: link_up high throughout, seen only at the first poll point
        run_seq(0, 6'h11, lat);
        check("R4", "cycles start-to-done", lat, 1 + A + NR + H + P + Q);
        check("R5", "done after held link", int'(done), 1);

        // R9 / R8: restart from done; a start while busy is ignored
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9", "done cleared on restart", int'(done), 0);
        while (!(mph == 3 && mt == 5)) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R8", "card still held after busy start", int'(card_rst_n), 0);
        check("R8", "still busy after busy start", int'(busy), 1);
        while (!(mph == 5 && mt >= 9)) begin
            link_up = 1'b0;
            @(negedge clk);
        end
        link_up = 1'b1;
        while (mph != 6 && mph != 7) @(negedge clk);
        link_up = 1'b0;
        @(negedge clk);
        check("R5", "done after mid-window link", int'(done), 1);

        // R6: no link, timeout captures LTSSM
        run_seq(2, 6'h15, lat);
        @(negedge clk);
        check("R6", "err on timeout", int'(err), 1);
        check("R6", "captured ltssm", int'(fail_ltssm), 'h15);
        repeat (4) @(negedge clk);
        check("R6", "err sticky", int'(err), 1);

        // R6: link present only at the final sample point wins
        run_seq(3, 6'h0a, lat);
        @(negedge clk);
        check("R6", "final-edge sample wins", int'(done), 1);

        // R4: link pulse between sample points is not seen
        run_seq(4, 6'h2c, lat);
        @(negedge clk);
        check("R4", "pulse between polls ignored", int'(err), 1);
        check("R4", "capture after ignored pulse", int'(fail_ltssm), 'h2c);

        // R9: restart from fail clears err and capture
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9", "err cleared on restart", int'(err), 0);
        check("R9", "capture cleared on restart", int'(fail_ltssm), 0);
        check("R2", "all asserted after restart", int'({core_rst_n, card_rst_n}), 0);
        while (mph != 6 && mph != 7) @(negedge clk);
        repeat (2) @(negedge clk);
        report();
    end
endmodule